// File: doc/BRIEF.md
# Host Slave Byte Port

This block lets an external bus master trade bytes with a local processor. The master sees two one-byte mailboxes behind a chip select: writing fills the input buffer, reading drains the output buffer. A command/data select line is captured with every master write and stored as a ninth bit beside the byte, so the local side can tell commands from data. The local processor reads the input buffer and writes the output buffer through single-cycle pulses. It sees a full flag for each buffer.

The master may use either of two strobe conventions, picked by a mode input. One uses a separate read strobe and write strobe. The other uses one data strobe plus a direction line. All master pins are asynchronous to the local clock. They pass through a synchronizer of parameterized depth, and each access completes on the strobe's release as seen in the clock domain. The data bus is delayed through the same number of stages, so the byte is taken from the sample made while the strobe was still low. A status output goes high when the master writes or the local side loads the output buffer. It goes low when the master reads.

Top module: `hsp_port`

## Requirements
- R1: After reset, the input-buffer-full flag, the output-buffer-full flag, the status output and the bus output enable are all 0.
- R2: With mode_ds = 0 and m_cs_n low, a master write is complete when m_wr_n rises. The bus value present while m_wr_n was low then appears on l_ibuf_data, and l_ibuf_full goes to 1.
- R3: The level of m_cd during a master write is stored beside the byte and shown on l_ibuf_cd (1 = command, 0 = data).
- R4: With mode_ds = 1, m_ds_n is the strobe and m_rw gives the direction (1 = master read, 0 = master write). The access completes when m_ds_n rises.
- R5: m_doe is 1 only while m_cs_n is low and a read is in progress. In mode 0 that means m_rd_n is low. In mode 1 it means m_ds_n is low with m_rw high. While m_doe is 1, m_dout carries the output-buffer byte.
- R6: A l_obuf_wr pulse loads l_obuf_wdata, sets l_obuf_full and drives status to 1. A completed master read clears l_obuf_full and drives status to 0.
- R7: A completed master write drives status to 1.
- R8: A l_ibuf_rd pulse clears l_ibuf_full and leaves l_ibuf_data unchanged.
- R9: A strobe pulse while m_cs_n is high changes neither buffer flag nor status.
- R10: Flags and status change on the (SYNC_STAGES+1)th rising clock edge after the completing strobe edge, and not before. A completion lasts one cycle.
- R11: A master write into a full input buffer overwrites the byte and the command/data bit, and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_ds | input | 1 | Strobe convention: 0 separate strobes, 1 data strobe plus direction |
| m_cs_n | input | 1 | Master chip select, active low |
| m_cd | input | 1 | Master command/data select |
| m_rd_n | input | 1 | Master read strobe (mode 0) |
| m_wr_n | input | 1 | Master write strobe (mode 0) |
| m_ds_n | input | 1 | Master data strobe (mode 1) |
| m_rw | input | 1 | Master direction, 1 read (mode 1) |
| m_din | input | DATA_W | Master bus data in |
| m_dout | output | DATA_W | Master bus data out |
| m_doe | output | 1 | Master bus output enable |
| status | output | 1 | Status line to master |
| l_ibuf_rd | input | 1 | Local read pulse for the input buffer |
| l_ibuf_data | output | DATA_W | Input buffer byte |
| l_ibuf_cd | output | 1 | Command/data bit stored with that byte |
| l_ibuf_full | output | 1 | Input buffer full |
| l_obuf_wr | input | 1 | Local write pulse for the output buffer |
| l_obuf_wdata | input | DATA_W | Output buffer write data |
| l_obuf_full | output | 1 | Output buffer full |

## Verification
A bad synchronizer or edge detector shows up as a full flag or status that moves too early, too late, or twice. The bench looks at the exact edge, SYNC_STAGES+1 clocks after the strobe release. A misaligned data delay stores the scrambled byte that the bench drives right after the release, so the error shows on l_ibuf_data as soon as the flag sets. Wrong chip-select gating or direction decoding appears at once on m_doe during the strobe, or on a flag after the next completion.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
   typedef struct packed {
      logic cs_n;
      logic cd;
      logic rd_n;
      logic wr_n;
      logic ds_n;
      logic rw;
   } hsp_ctl_t;

   localparam int CTL_W = $bits(hsp_ctl_t);

   localparam hsp_ctl_t CTL_IDLE = '{cs_n: 1'b1, cd: 1'b0, rd_n: 1'b1,
                                     wr_n: 1'b1, ds_n: 1'b1, rw: 1'b1};

   typedef enum logic {STB_SPLIT = 1'b0, STB_DS = 1'b1} stb_mode_e;
endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_depth
      $error("hsp_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("hsp_sync: W must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/hsp_strobe_det.sv
module hsp_strobe_det
   import hsp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_ds,
   input  hsp_ctl_t          ctl_s,
   input  logic [DATA_W-1:0] din_s,
   output logic              wr_done,
   output logic              rd_done,
   output logic [DATA_W-1:0] wr_byte,
   output logic              wr_cd
);
   hsp_ctl_t          prev_ctl;
   logic [DATA_W-1:0] prev_din;
   stb_mode_e         mode;
   logic              rd_rel, wr_rel, ds_rel;

   assign mode = stb_mode_e'(mode_ds);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_ctl <= CTL_IDLE;
         prev_din <= '0;
      end else begin
         prev_ctl <= ctl_s;
         prev_din <= din_s;
      end
   end

   // release of a strobe seen in the clock domain; cs and direction from the low sample
   always_comb begin
      rd_rel = !prev_ctl.rd_n && ctl_s.rd_n;
      wr_rel = !prev_ctl.wr_n && ctl_s.wr_n;
      ds_rel = !prev_ctl.ds_n && ctl_s.ds_n;
      if (mode == STB_DS) begin
         rd_done = ds_rel &&  prev_ctl.rw && !prev_ctl.cs_n;
         wr_done = ds_rel && !prev_ctl.rw && !prev_ctl.cs_n;
      end else begin
         rd_done = rd_rel && !prev_ctl.cs_n;
         wr_done = wr_rel && !prev_ctl.cs_n;
      end
   end

   assign wr_byte = prev_din;
   assign wr_cd   = prev_ctl.cd;

   AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |=> !rd_done); // R10
   AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |=> !wr_done); // R10
endmodule

// File: rtl/hsp_bufs.sv
module hsp_bufs #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_done,
   input  logic [DATA_W-1:0] wr_byte,
   input  logic              wr_cd,
   input  logic              rd_done,
   input  logic              l_ibuf_rd,
   input  logic              l_obuf_wr,
   input  logic [DATA_W-1:0] l_obuf_wdata,
   output logic [DATA_W-1:0] ibuf_data,
   output logic              ibuf_cd,
   output logic              ibuf_full,
   output logic [DATA_W-1:0] obuf_data,
   output logic              obuf_full,
   output logic              status
);
   // input buffer: a master write wins over a local read in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ibuf_data <= '0;
         ibuf_cd   <= 1'b0;
         ibuf_full <= 1'b0;
      end else if (wr_done) begin
         ibuf_data <= wr_byte;
         ibuf_cd   <= wr_cd;
         ibuf_full <= 1'b1;
      end else if (l_ibuf_rd) begin
         ibuf_full <= 1'b0;
      end
   end

   // output buffer: a local load wins over a master read in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         obuf_data <= '0;
         obuf_full <= 1'b0;
      end else if (l_obuf_wr) begin
         obuf_data <= l_obuf_wdata;
         obuf_full <= 1'b1;
      end else if (rd_done) begin
         obuf_full <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   status <= 1'b0;
      else if (wr_done || l_obuf_wr) status <= 1'b1;
      else if (rd_done)             status <= 1'b0;
   end

   AST_IBF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |=> ibuf_full); // R2
   AST_IBF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ibuf_full && !wr_done && !l_ibuf_rd) |=> (ibuf_full && $stable(ibuf_data))); // R8
   AST_OBF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_done && !l_obuf_wr) |=> (!obuf_full && !status)); // R6
   AST_STS_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_done || l_obuf_wr) |=> status); // R7
endmodule

// File: rtl/hsp_port.sv
module hsp_port
   import hsp_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_ds,
   input  logic              m_cs_n,
   input  logic              m_cd,
   input  logic              m_rd_n,
   input  logic              m_wr_n,
   input  logic              m_ds_n,
   input  logic              m_rw,
   input  logic [DATA_W-1:0] m_din,
   output logic [DATA_W-1:0] m_dout,
   output logic              m_doe,
   output logic              status,
   input  logic              l_ibuf_rd,
   output logic [DATA_W-1:0] l_ibuf_data,
   output logic              l_ibuf_cd,
   output logic              l_ibuf_full,
   input  logic              l_obuf_wr,
   input  logic [DATA_W-1:0] l_obuf_wdata,
   output logic              l_obuf_full
);
   if (DATA_W < 1) begin : g_bad_dw
      $error("hsp_port: DATA_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("hsp_port: SYNC_STAGES must be at least 2");
   end

   hsp_ctl_t          ctl_raw, ctl_s;
   logic [CTL_W-1:0]  ctl_s_vec;
   logic [DATA_W-1:0] din_s, wr_byte, obuf_data;
   logic              wr_done, rd_done, wr_cd, rd_live;

   assign ctl_raw = '{cs_n: m_cs_n, cd: m_cd, rd_n: m_rd_n,
                      wr_n: m_wr_n, ds_n: m_ds_n, rw: m_rw};

   hsp_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_sync_ctl (
      .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s_vec));
   assign ctl_s = hsp_ctl_t'(ctl_s_vec);

   // data delayed by the same depth so it lines up with the strobe samples
   hsp_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_dat (
      .clk(clk), .rst_n(rst_n), .d(m_din), .q(din_s));

   hsp_strobe_det #(.DATA_W(DATA_W)) u_det (
      .clk(clk), .rst_n(rst_n), .mode_ds(mode_ds), .ctl_s(ctl_s), .din_s(din_s),
      .wr_done(wr_done), .rd_done(rd_done), .wr_byte(wr_byte), .wr_cd(wr_cd));

   hsp_bufs #(.DATA_W(DATA_W)) u_bufs (
      .clk(clk), .rst_n(rst_n), .wr_done(wr_done), .wr_byte(wr_byte), .wr_cd(wr_cd),
      .rd_done(rd_done), .l_ibuf_rd(l_ibuf_rd), .l_obuf_wr(l_obuf_wr),
      .l_obuf_wdata(l_obuf_wdata), .ibuf_data(l_ibuf_data), .ibuf_cd(l_ibuf_cd),
      .ibuf_full(l_ibuf_full), .obuf_data(obuf_data), .obuf_full(l_obuf_full),
      .status(status));

   // bus drive follows the raw pins so data is on the bus within the strobe
   always_comb begin
      if (stb_mode_e'(mode_ds) == STB_DS) rd_live = !m_ds_n && m_rw;
      else                                rd_live = !m_rd_n;
   end
   assign m_doe  = !m_cs_n && rd_live;
   assign m_dout = m_doe ? obuf_data : '0;

   AST_DOE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(m_doe) |-> !m_cs_n); // R5
endmodule

// File: tb/sim_hsp_port.sv
module sim_hsp_port;
   localparam int CLK_P = 10;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst_n, mode_ds, m_cs_n, m_cd, m_rd_n, m_wr_n, m_ds_n, m_rw;
   logic [DW-1:0] m_din, m_dout, l_ibuf_data, l_obuf_wdata;
   logic m_doe, status, l_ibuf_rd, l_ibuf_cd, l_ibuf_full, l_obuf_wr, l_obuf_full;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   hsp_port #(.DATA_W(DW), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_ds(mode_ds), .m_cs_n(m_cs_n), .m_cd(m_cd),
      .m_rd_n(m_rd_n), .m_wr_n(m_wr_n), .m_ds_n(m_ds_n), .m_rw(m_rw), .m_din(m_din),
      .m_dout(m_dout), .m_doe(m_doe), .status(status), .l_ibuf_rd(l_ibuf_rd),
      .l_ibuf_data(l_ibuf_data), .l_ibuf_cd(l_ibuf_cd), .l_ibuf_full(l_ibuf_full),
      .l_obuf_wr(l_obuf_wr), .l_obuf_wdata(l_obuf_wdata), .l_obuf_full(l_obuf_full));

   // {mode, cd, byte}
   localparam logic [9:0] VEC [6] = '{
      {1'b0, 1'b0, 8'h5A}, {1'b0, 1'b1, 8'hC3}, {1'b1, 1'b0, 8'h01},
      {1'b1, 1'b1, 8'hFE}, {1'b0, 1'b1, 8'h80}, {1'b1, 1'b0, 8'h7F}};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle_pins();
      m_cs_n = 1'b1; m_cd = 1'b0; m_rd_n = 1'b1; m_wr_n = 1'b1;
      m_ds_n = 1'b1; m_rw = 1'b1;
   endtask

   task automatic master_write(input logic md, input logic csel, input logic cd,
                               input logic [DW-1:0] dat);
      @(negedge clk);
      mode_ds = md; m_cs_n = !csel; m_cd = cd; m_din = dat;
      if (md) begin m_rw = 1'b0; m_ds_n = 1'b0; end
      else    m_wr_n = 1'b0;
      @(negedge clk);
      chk("R5 no drive during write", m_doe, 1'b0);
      repeat (2) @(negedge clk);
      m_wr_n = 1'b1; m_ds_n = 1'b1; m_din = ~dat;
      repeat (4) @(negedge clk);
      idle_pins();
   endtask

   task automatic master_read(input logic md, input logic csel,
                              input logic exp_doe, input logic [DW-1:0] exp_dat);
      @(negedge clk);
      mode_ds = md; m_cs_n = !csel;
      if (md) begin m_rw = 1'b1; m_ds_n = 1'b0; end
      else    m_rd_n = 1'b0;
      #1;
      chk("R5 read drive enable", m_doe, exp_doe);
      chk("R5 read data", m_dout, exp_doe ? exp_dat : '0);
      repeat (3) @(negedge clk);
      m_rd_n = 1'b1; m_ds_n = 1'b1;
      repeat (4) @(negedge clk);
      idle_pins();
   endtask

   task automatic local_ibuf_read();
      @(negedge clk); l_ibuf_rd = 1'b1;
      @(negedge clk); l_ibuf_rd = 1'b0;
   endtask

   task automatic local_obuf_write(input logic [DW-1:0] dat);
      @(negedge clk); l_obuf_wr = 1'b1; l_obuf_wdata = dat;
      @(negedge clk); l_obuf_wr = 1'b0;
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; mode_ds = 1'b0; idle_pins(); m_din = '0;
      l_ibuf_rd = 1'b0; l_obuf_wr = 1'b0; l_obuf_wdata = '0;
      repeat (3) @(negedge clk);
      chk("R1 ibuf_full", l_ibuf_full, 1'b0);
      chk("R1 obuf_full", l_obuf_full, 1'b0);
      chk("R1 status", status, 1'b0);
      chk("R1 doe", m_doe, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // table walk: writes in both strobe modes (R2, R3, R4, R7, R8)
      foreach (VEC[i]) begin
         master_write(VEC[i][9], 1'b1, VEC[i][8], VEC[i][7:0]);
         chk(VEC[i][9] ? "R4 ibuf_full" : "R2 ibuf_full", l_ibuf_full, 1'b1);
         chk(VEC[i][9] ? "R4 ibuf_data" : "R2 ibuf_data", l_ibuf_data, VEC[i][7:0]);
         chk("R3 ibuf_cd", l_ibuf_cd, VEC[i][8]);
         chk("R7 status after write", status, 1'b1);
         local_ibuf_read();
         chk("R8 ibuf_full cleared", l_ibuf_full, 1'b0);
         chk("R8 data held", l_ibuf_data, VEC[i][7:0]);
      end

      // R10 latency: flag moves on the third rising edge after release
      @(negedge clk);
      mode_ds = 1'b0; m_cs_n = 1'b0; m_cd = 1'b0; m_din = 8'h96; m_wr_n = 1'b0;
      repeat (3) @(negedge clk);
      m_wr_n = 1'b1; m_din = 8'h00;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R10 not yet after two edges", l_ibuf_full, 1'b0);
      @(negedge clk);
      chk("R10 set on third edge", l_ibuf_full, 1'b1);
      chk("R10 byte", l_ibuf_data, 8'h96);
      repeat (2) @(negedge clk);
      idle_pins();
      local_ibuf_read();

      // R11 overwrite while full
      master_write(1'b0, 1'b1, 1'b0, 8'h11);
      master_write(1'b1, 1'b1, 1'b1, 8'h22);
      chk("R11 overwrite data", l_ibuf_data, 8'h22);
      chk("R11 overwrite cd", l_ibuf_cd, 1'b1);
      chk("R11 still full", l_ibuf_full, 1'b1);
      local_ibuf_read();

      // R6 local load then master read in split-strobe mode
      local_obuf_write(8'hA5);
      chk("R6 obuf_full set", l_obuf_full, 1'b1);
      chk("R6 status high on load", status, 1'b1);
      master_read(1'b0, 1'b1, 1'b1, 8'hA5);
      chk("R6 obuf_full cleared", l_obuf_full, 1'b0);
      chk("R6 status low after read", status, 1'b0);

      // R9 accesses with chip select inactive
      master_write(1'b0, 1'b0, 1'b1, 8'h44);
      chk("R9 ibuf_full untouched", l_ibuf_full, 1'b0);
      chk("R9 status untouched", status, 1'b0);
      local_obuf_write(8'h3C);
      master_read(1'b0, 1'b0, 1'b0, 8'h00);
      chk("R9 obuf_full kept", l_obuf_full, 1'b1);
      chk("R9 status kept", status, 1'b1);
      master_read(1'b1, 1'b0, 1'b0, 8'h00);
      chk("R9 obuf_full kept ds", l_obuf_full, 1'b1);

      // R4 read in data-strobe mode
      master_read(1'b1, 1'b1, 1'b1, 8'h3C);
      chk("R4 obuf_full cleared", l_obuf_full, 1'b0);
      chk("R4 status low", status, 1'b0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule